// File: doc/BRIEF.md
# Programming Pin Pulse Decoder

A sensor that is trimmed through its output pin sees three kinds of excursion on that pin: a high programming level, a low programming level and a near-zero level that clears unfused settings. Comparators outside this block turn those levels into three synchronous flags. The decoder turns the flags into clean internal events for the programming state machine. It measures each high pulse against a 1 µs timebase tick. When the high pulse ends, the decoder labels it either a short state-change strobe or a long fuse-blow request. It also holds a stretched internal high window, which lasts past the end of the external pulse by a fixed tail. Each low pulse produces an internal window of fixed length. The decoder detects when the pin comes back up before that window has finished.

Guard bands keep the downstream logic clear of pulses that come too close together. Any edge that arrives while an earlier pulse is still settling is dropped and recorded in a sticky flag. When the pin leaves the clearing level it passes through the low band, and the decoder models the stray low pulse this passage produces. While the clearing level is present, every output is held low and every timer is cleared.

Top module: `prog_pulse_decoder`

## Requirements
- R1: A rising edge of `hi_lvl` that is accepted raises `hi_pulse` on the next clock. `hi_pulse` stays high while `hi_lvl` is high, and for a further `TAIL_US` ticks (15 by default, within one tick) after `hi_lvl` falls.
- R2: When an accepted high pulse ends, exactly one of `strobe_evt` and `blow_evt` is high, for exactly one clock. That clock is the one after the clock edge where `hi_lvl` is first seen low.
- R3: The width is counted in ticks, from the accepting edge through the last edge at which `hi_lvl` is high. A width of fewer than `BLOW_MIN_US` ticks (35 by default) gives `strobe_evt`. A width of `BLOW_MIN_US` ticks or more gives `blow_evt`.
- R4: A rising edge of `lo_lvl` that is accepted raises `lo_pulse` on the next clock. `lo_pulse` stays high for `LO_LEN_US` ticks (5 by default, within one tick) and then falls, whatever `lo_lvl` does after that.
- R5: If `lo_lvl` drops while an ordinary `lo_pulse` is high, `lo_pulse` falls on the next clock and `lo_trunc_err` goes high. `lo_trunc_err` then stays high until reset.
- R6: When `rst_lvl` falls, a stray low pulse begins: `lo_pulse` rises on the next clock and runs its full length. This pulse cannot be truncated. Any `lo_lvl` edge that comes before the stray pulse's guard ends is ignored and raises no flag.
- R7: A rising edge of either flag that comes within `HI_GUARD_US` ticks (20 by default) after a high pulse ends starts nothing, and it sets the sticky `guard_viol`.
- R8: A rising edge of either flag that comes within `LO_GUARD_US` ticks (6 by default) after the start of an ordinary low pulse starts nothing, and it sets `guard_viol`.
- R9: While `rst_lvl` is high, every output is low. All timers, the sticky `guard_viol` and the sticky `lo_trunc_err` are cleared, and a high pulse interrupted this way produces no event.
- R10: After `rst_n` is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-clock tick once per microsecond |
| hi_lvl | input | 1 | Pin is at the high programming level |
| lo_lvl | input | 1 | Pin is at the low programming level |
| rst_lvl | input | 1 | Pin is at the clearing level |
| strobe_evt | output | 1 | One-clock event: a short high pulse ended |
| blow_evt | output | 1 | One-clock event: a long high pulse ended |
| hi_pulse | output | 1 | Stretched internal high window |
| lo_pulse | output | 1 | Fixed-length internal low window |
| lo_trunc_err | output | 1 | Sticky: a low window was cut short |
| guard_viol | output | 1 | Sticky: an edge arrived inside a guard band |

## Verification
A width counter that is off by one shows up at the 34/35-tick boundary as the wrong class of event, on the clock after the fall. A wrong tail or guard count shows up as `hi_pulse` or `lo_pulse` ending on the wrong side of a check point a few microseconds later. It can also show as `guard_viol` changing when an edge arrives near the end of the guard. A state that is not cleared at the clearing level shows up at once as a stray event or a stray flag after the level is released. A stray pulse that can be truncated raises `lo_trunc_err` within a clock of the drop in `lo_lvl`.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

  localparam int unsigned CNT_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    HI_IDLE = 2'd0,
    HI_WIDE = 2'd1,
    HI_POST = 2'd2
  } hi_st_e;

  typedef enum logic [1:0] {
    LO_IDLE = 2'd0,
    LO_ON   = 2'd1,
    LO_HOLD = 2'd2
  } lo_st_e;

  // counter value on the cycle a window opens: the opening edge counts its tick
  function automatic cnt_t first_count(logic tk);
    return tk ? cnt_t'(1) : '0;
  endfunction

  // saturating advance on a tick
  function automatic cnt_t tick_adv(cnt_t c, logic tk, cnt_t cap);
    if (tk && (c < cap)) return c + 1'b1;
    return c;
  endfunction

  // this tick completes a window of lim ticks
  function automatic logic tick_hits(cnt_t c, logic tk, cnt_t lim);
    return tk && ((c + 1'b1) >= lim);
  endfunction

  // width classification of a finished high pulse
  function automatic logic width_is_blow(cnt_t w, cnt_t lim);
    return w >= lim;
  endfunction

endpackage

// File: rtl/pkd_edge_front.sv
module pkd_edge_front (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_lvl,
  input  logic lo_lvl,
  input  logic rst_lvl,
  output logic hi_rise,
  output logic lo_rise,
  output logic lvl_exit
);

  logic hi_q;
  logic lo_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      hi_q  <= hi_lvl;
      lo_q  <= lo_lvl;
      rst_q <= rst_lvl;
    end
  end

  assign hi_rise  = hi_lvl & ~hi_q & ~rst_lvl;
  assign lo_rise  = lo_lvl & ~lo_q & ~rst_lvl;
  assign lvl_exit = rst_q & ~rst_lvl;

  AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_exit |=> !lvl_exit); // R6

endmodule

// File: rtl/pkd_hi_shaper.sv
module pkd_hi_shaper
  import pkd_pkg::*;
#(
  parameter int unsigned TAIL_US     = 15,
  parameter int unsigned BLOW_MIN_US = 35,
  parameter int unsigned GUARD_US    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic hi_lvl,
  input  logic start,
  output logic busy,
  output logic hi_win,
  output logic strobe_evt,
  output logic blow_evt,
  output logic fall_evt
);

  localparam cnt_t TAIL_C  = cnt_t'(TAIL_US);
  localparam cnt_t BLOW_C  = cnt_t'(BLOW_MIN_US);
  localparam cnt_t GUARD_C = cnt_t'(GUARD_US);

  hi_st_e st;
  cnt_t   wcnt;
  cnt_t   pcnt;
  logic   strobe_q;
  logic   blow_q;

  assign fall_evt = (st == HI_WIDE) && !hi_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st       <= HI_IDLE;
      wcnt     <= '0;
      pcnt     <= '0;
      strobe_q <= 1'b0;
      blow_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      blow_q   <= 1'b0;
      unique case (st)
        HI_IDLE: begin
          if (start) begin
            st   <= HI_WIDE;
            wcnt <= first_count(tick);
          end
        end
        HI_WIDE: begin
          if (!hi_lvl) begin
            st       <= HI_POST;
            pcnt     <= first_count(tick);
            blow_q   <= width_is_blow(wcnt, BLOW_C);
            strobe_q <= !width_is_blow(wcnt, BLOW_C);
          end else begin
            wcnt <= tick_adv(wcnt, tick, BLOW_C);
          end
        end
        HI_POST: begin
          if (tick_hits(pcnt, tick, GUARD_C)) st <= HI_IDLE;
          else pcnt <= tick_adv(pcnt, tick, GUARD_C);
        end
        default: st <= HI_IDLE;
      endcase
    end
  end

  assign busy       = (st != HI_IDLE);
  assign hi_win     = (st == HI_WIDE) || ((st == HI_POST) && (pcnt < TAIL_C));
  assign strobe_evt = strobe_q;
  assign blow_evt   = blow_q;

  AST_WIN_FROM_START: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(hi_win) |-> $past(start)); // R1
  AST_TAIL_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (strobe_evt || blow_evt) |-> hi_win); // R1
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n || clr)
    fall_evt |=> (strobe_evt ^ blow_evt)); // R2
  AST_EVT_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (strobe_evt || blow_evt) |-> $past(fall_evt)); // R2
  AST_BLOW_WIDE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    blow_evt |-> ($past(wcnt) >= BLOW_C)); // R3
  AST_STROBE_NARROW: assert property (@(posedge clk) disable iff (!rst_n || clr)
    strobe_evt |-> ($past(wcnt) < BLOW_C)); // R3

endmodule

// File: rtl/pkd_lo_timer.sv
module pkd_lo_timer
  import pkd_pkg::*;
#(
  parameter int unsigned LEN_US   = 5,
  parameter int unsigned GUARD_US = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic lo_lvl,
  input  logic start,
  input  logic start_spur,
  output logic busy,
  output logic spur_win,
  output logic lo_win,
  output logic abort_evt,
  output logic abort_err
);

  localparam cnt_t LEN_C   = cnt_t'(LEN_US);
  localparam cnt_t GUARD_C = cnt_t'(GUARD_US);

  lo_st_e st;
  cnt_t   cnt;
  logic   spur_q;
  logic   err_q;

  assign abort_evt = (st == LO_ON) && !spur_q && !lo_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st     <= LO_IDLE;
      cnt    <= '0;
      spur_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        LO_IDLE: begin
          if (start || start_spur) begin
            st     <= LO_ON;
            cnt    <= first_count(tick);
            spur_q <= start_spur;
          end
        end
        LO_ON: begin
          cnt <= tick_adv(cnt, tick, GUARD_C);
          if (abort_evt) begin
            st    <= LO_HOLD;
            err_q <= 1'b1;
          end else if (tick_hits(cnt, tick, LEN_C)) begin
            st <= LO_HOLD;
          end
        end
        LO_HOLD: begin
          if (tick_hits(cnt, tick, GUARD_C)) begin
            st     <= LO_IDLE;
            spur_q <= 1'b0;
          end else begin
            cnt <= tick_adv(cnt, tick, GUARD_C);
          end
        end
        default: st <= LO_IDLE;
      endcase
    end
  end

  assign busy      = (st != LO_IDLE);
  assign lo_win    = (st == LO_ON);
  assign spur_win  = spur_q;
  assign abort_err = err_q;

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n || clr)
    lo_win |-> (cnt < LEN_C)); // R4
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n || clr)
    abort_evt |=> (!lo_win && abort_err)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || clr)
    abort_err |=> abort_err); // R5
  AST_SPUR_UNCUT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (lo_win && spur_win && !abort_err) |=> !abort_err); // R6

endmodule

// File: rtl/prog_pulse_decoder.sv
module prog_pulse_decoder
  import pkd_pkg::*;
#(
  parameter int unsigned TAIL_US     = 15,
  parameter int unsigned BLOW_MIN_US = 35,
  parameter int unsigned HI_GUARD_US = 20,
  parameter int unsigned LO_LEN_US   = 5,
  parameter int unsigned LO_GUARD_US = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic hi_lvl,
  input  logic lo_lvl,
  input  logic rst_lvl,
  output logic strobe_evt,
  output logic blow_evt,
  output logic hi_pulse,
  output logic lo_pulse,
  output logic lo_trunc_err,
  output logic guard_viol
);

  logic hi_rise, lo_rise, lvl_exit;
  logic hi_busy, hi_win, hi_strobe, hi_blow, hi_fall;
  logic lo_busy, spur_win, lo_win, lo_abort, lo_err;
  logic accept_hi, accept_lo, bad_edge;
  logic guard_q;

  pkd_edge_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_lvl   (hi_lvl),
    .lo_lvl   (lo_lvl),
    .rst_lvl  (rst_lvl),
    .hi_rise  (hi_rise),
    .lo_rise  (lo_rise),
    .lvl_exit (lvl_exit)
  );

  // one pulse path at a time; the exit edge belongs to the stray low pulse
  assign accept_hi = hi_rise & ~hi_busy & ~lo_busy & ~lvl_exit;
  assign accept_lo = lo_rise & ~hi_busy & ~lo_busy & ~lvl_exit;
  assign bad_edge  = (hi_rise & ~accept_hi)
                   | (lo_rise & ~accept_lo & ~spur_win & ~lvl_exit);

  pkd_hi_shaper #(
    .TAIL_US     (TAIL_US),
    .BLOW_MIN_US (BLOW_MIN_US),
    .GUARD_US    (HI_GUARD_US)
  ) u_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rst_lvl),
    .tick       (tick_us),
    .hi_lvl     (hi_lvl),
    .start      (accept_hi),
    .busy       (hi_busy),
    .hi_win     (hi_win),
    .strobe_evt (hi_strobe),
    .blow_evt   (hi_blow),
    .fall_evt   (hi_fall)
  );

  pkd_lo_timer #(
    .LEN_US   (LO_LEN_US),
    .GUARD_US (LO_GUARD_US)
  ) u_lo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rst_lvl),
    .tick       (tick_us),
    .lo_lvl     (lo_lvl),
    .start      (accept_lo),
    .start_spur (lvl_exit),
    .busy       (lo_busy),
    .spur_win   (spur_win),
    .lo_win     (lo_win),
    .abort_evt  (lo_abort),
    .abort_err  (lo_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || rst_lvl) guard_q <= 1'b0;
    else if (bad_edge)     guard_q <= 1'b1;
  end

  assign strobe_evt   = hi_strobe & ~rst_lvl;
  assign blow_evt     = hi_blow   & ~rst_lvl;
  assign hi_pulse     = hi_win    & ~rst_lvl;
  assign lo_pulse     = lo_win    & ~rst_lvl;
  assign lo_trunc_err = lo_err    & ~rst_lvl;
  assign guard_viol   = guard_q   & ~rst_lvl;

  AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_busy && lo_busy)); // R7
  AST_HI_GUARD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rise && hi_busy) |=> (guard_viol || rst_lvl)); // R7
  AST_LO_GUARD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rise && lo_busy && !spur_win) |=> (!hi_pulse && (guard_viol || rst_lvl))); // R8
  AST_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_lvl && $past(rst_lvl)) |-> (!hi_busy && !lo_busy && !guard_q)); // R9
  AST_EXIT_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_lvl) |=> (lo_pulse || rst_lvl)); // R6

endmodule

// File: tb/prog_pulse_decoder_tb_top.sv
module prog_pulse_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic hi_lvl = 1'b0;
  logic lo_lvl = 1'b0;
  logic rst_lvl = 1'b0;
  logic strobe_evt, blow_evt, hi_pulse, lo_pulse, lo_trunc_err, guard_viol;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int tdiv = 0;

  localparam int CYC_PER_US = 4;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv    = (tdiv + 1) % CYC_PER_US;
    tick_us = (tdiv == 0);
  end

  prog_pulse_decoder dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_us      (tick_us),
    .hi_lvl       (hi_lvl),
    .lo_lvl       (lo_lvl),
    .rst_lvl      (rst_lvl),
    .strobe_evt   (strobe_evt),
    .blow_evt     (blow_evt),
    .hi_pulse     (hi_pulse),
    .lo_pulse     (lo_pulse),
    .lo_trunc_err (lo_trunc_err),
    .guard_viol   (guard_viol)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clearing level pulse, then settle past any stray low pulse
  task automatic level_clear();
    rst_lvl = 1'b1;
    cyc(1);
    chk("R9", "hi_pulse under clear", hi_pulse, 1'b0);
    chk("R9", "guard_viol under clear", guard_viol, 1'b0);
    chk("R9", "lo_trunc_err under clear", lo_trunc_err, 1'b0);
    cyc(7);
    rst_lvl = 1'b0;
    cyc(40);
    chk("R9", "guard_viol after clear", guard_viol, 1'b0);
    chk("R9", "lo_trunc_err after clear", lo_trunc_err, 1'b0);
  endtask

  // high pulse of w ticks; expects strobe or blow class
  task automatic t_high_pulse(input int w, input logic exp_blow);
    hi_lvl = 1'b1;
    cyc(1);
    chk("R1", "hi_pulse after rise", hi_pulse, 1'b1);
    cyc(w * CYC_PER_US - 1);
    chk("R1", "hi_pulse while high", hi_pulse, 1'b1);
    chk("R2", "no event while high", strobe_evt | blow_evt, 1'b0);
    hi_lvl = 1'b0;
    cyc(1);
    chk("R3", "strobe class", strobe_evt, !exp_blow);
    chk("R3", "blow class", blow_evt, exp_blow);
    chk("R1", "hi_pulse at fall", hi_pulse, 1'b1);
    cyc(1);
    chk("R2", "event lasts one clock", strobe_evt | blow_evt, 1'b0);
    cyc(48);
    chk("R1", "tail still high at 13us", hi_pulse, 1'b1);
    cyc(20);
    chk("R1", "tail ended by 17us", hi_pulse, 1'b0);
    cyc(24);
    chk("R7", "no guard flag for spaced pulse", guard_viol, 1'b0);
  endtask

  task automatic t_hi_guard();
    hi_lvl = 1'b1;
    cyc(40);
    hi_lvl = 1'b0;
    cyc(68);
    chk("R7", "tail over before retry", hi_pulse, 1'b0);
    hi_lvl = 1'b1;
    cyc(1);
    chk("R7", "retry ignored", hi_pulse, 1'b0);
    chk("R7", "guard_viol set", guard_viol, 1'b1);
    cyc(8);
    hi_lvl = 1'b0;
    cyc(1);
    chk("R7", "no event for ignored pulse", strobe_evt | blow_evt, 1'b0);
    cyc(40);
    chk("R7", "guard_viol sticky", guard_viol, 1'b1);
    level_clear();
  endtask

  task automatic t_lo_normal();
    lo_lvl = 1'b1;
    cyc(1);
    chk("R4", "lo_pulse after start", lo_pulse, 1'b1);
    cyc(11);
    chk("R4", "lo_pulse at 3us", lo_pulse, 1'b1);
    cyc(12);
    chk("R4", "lo_pulse ended by 6us", lo_pulse, 1'b0);
    chk("R4", "no trunc on full pulse", lo_trunc_err, 1'b0);
    cyc(8);
    lo_lvl = 1'b0;
    cyc(1);
    chk("R4", "late release harmless", lo_trunc_err, 1'b0);
    chk("R8", "release after guard no flag", guard_viol, 1'b0);
    cyc(8);
  endtask

  task automatic t_lo_abort();
    lo_lvl = 1'b1;
    cyc(8);
    chk("R5", "lo_pulse before drop", lo_pulse, 1'b1);
    lo_lvl = 1'b0;
    cyc(1);
    chk("R5", "lo_pulse cut", lo_pulse, 1'b0);
    chk("R5", "trunc flag set", lo_trunc_err, 1'b1);
    cyc(40);
    chk("R5", "trunc flag sticky", lo_trunc_err, 1'b1);
    level_clear();
  endtask

  task automatic t_lo_guard();
    lo_lvl = 1'b1;
    cyc(8);
    lo_lvl = 1'b0;
    cyc(1);
    hi_lvl = 1'b1;
    cyc(1);
    chk("R8", "high inside low guard ignored", hi_pulse, 1'b0);
    chk("R8", "guard_viol set", guard_viol, 1'b1);
    cyc(8);
    hi_lvl = 1'b0;
    cyc(1);
    chk("R8", "no event for ignored high", strobe_evt | blow_evt, 1'b0);
    level_clear();
  endtask

  task automatic t_level_exit();
    hi_lvl = 1'b1;
    cyc(20);
    rst_lvl = 1'b1;
    #1;
    chk("R9", "hi_pulse forced low", hi_pulse, 1'b0);
    cyc(4);
    hi_lvl = 1'b0;
    cyc(4);
    rst_lvl = 1'b0;
    cyc(1);
    chk("R6", "stray lo_pulse on exit", lo_pulse, 1'b1);
    chk("R9", "no event from cleared high", strobe_evt | blow_evt, 1'b0);
    lo_lvl = 1'b1;
    cyc(4);
    lo_lvl = 1'b0;
    cyc(1);
    chk("R6", "stray pulse not cut", lo_pulse, 1'b1);
    chk("R6", "no trunc on stray", lo_trunc_err, 1'b0);
    chk("R6", "stray edges raise no flag", guard_viol, 1'b0);
    cyc(40);
    chk("R6", "stray pulse ended", lo_pulse, 1'b0);
    chk("R6", "still no flag", guard_viol, 1'b0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R10", "strobe after reset", strobe_evt, 1'b0);
    chk("R10", "blow after reset", blow_evt, 1'b0);
    chk("R10", "hi_pulse after reset", hi_pulse, 1'b0);
    chk("R10", "lo_pulse after reset", lo_pulse, 1'b0);
    chk("R10", "trunc after reset", lo_trunc_err, 1'b0);
    chk("R10", "guard after reset", guard_viol, 1'b0);
    t_high_pulse(10, 1'b0);
    t_high_pulse(34, 1'b0);
    t_high_pulse(35, 1'b1);
    t_high_pulse(60, 1'b1);
    t_hi_guard();
    t_lo_normal();
    t_lo_abort();
    t_lo_guard();
    t_level_exit();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule